// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a chip. It holds the sixteen-state port controller, an eight-bit instruction register with its decoder, and three data paths: a one-bit bypass stage, a 32-bit identification word, and a boundary chain whose length is a parameter. A tester steps the controller with TMS on rising edges of TCK, shifts instructions and data in on TDI, and reads results on TDO. TDO is driven only while a register is being shifted.

Toward the core, the boundary chain samples the chip's pin values in parallel. Its update stage can take over the pins through an override select. A `programmed` input gates the external-test instruction. Until it is high, that opcode falls back to bypass and never takes the pins. A clamp instruction holds the pins at the update-stage value while the short bypass path sits between TDI and TDO.

Top module: `jtag_tap_port`

## Requirements
- R1: TRST_N low resets the controller to Test-Logic-Reset at once, without waiting for a clock edge. It also makes the identification instruction (0x0F) active and disables TDO.
- R2: With TMS held at 1, at most five rising TCK edges reach Test-Logic-Reset from any state. Entering that state makes 0x0F the active instruction.
- R3: Capture-IR loads 0x01 into the instruction shift stage. Shifting is least significant bit first: TDI enters at bit 7 and bit 0 appears on TDO.
- R4: Opcode 0x0F selects the 32-bit identification register. Capture-DR loads parameter ID_CODE into it, whose bit 0 is 1, and the register shifts out least significant bit first.
- R5: Opcode 0xFF, and every opcode other than 0x00, 0x01, 0x05 and 0x0F, selects the bypass stage. The bypass stage captures 0 and delays TDI by one shift.
- R6: Opcode 0x01 (sample/preload) does three things. Capture-DR copies pin_in into the boundary chain. Update-DR, on the falling edge, copies the chain into the update stage seen on pin_out. pin_override stays 0.
- R7: Opcode 0x00 (external test) with programmed = 1 behaves as follows. The boundary chain captures pin_in and updates like R6, and pin_override is 1.
- R8: Opcode 0x00 with programmed = 0 behaves as bypass (R5). pin_override stays 0.
- R9: Opcode 0x05 (clamp) selects the bypass stage and sets pin_override to 1. pin_out keeps the update-stage value through data scans.
- R10: The active instruction changes only on a falling TCK edge in Update-IR or Test-Logic-Reset. Shifting a new opcode leaves the pin control unchanged until Update-IR.
- R11: TDO changes on falling TCK edges. It is enabled (tdo_oe = 1) only in Shift-IR and Shift-DR and is high-impedance otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select, sampled on rising TCK |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, high-impedance when disabled |
| tdo_oe | output | 1 | TDO output enable |
| programmed | input | 1 | High once the device is configured; permits external test |
| pin_in | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| pin_out | output | BSR_LEN | Boundary update stage driven toward the pins |
| pin_override | output | 1 | High when pin_out must replace core values on the pins |

## Verification
The bench loads the external-test opcode with `programmed` low. A design that decoded the opcode without the flag would take the pins and would scan the boundary chain instead of the one-bit delay. The bench also reads pin_override between the last IR shift and Update-IR. A design that applied the shift stage directly would switch pin control mid-scan. Further scenarios: async TRST is pulsed in the middle of a data scan, and TMS is held high from Shift-DR to check the five-edge return to reset. An unlisted opcode must fall into bypass, not select some other register. A bypass that captured 1, or a TDO that moved on rising edges, would show up as a shifted or corrupted readout.

// File: rtl/jtag_tap_port.sv
module jtag_tap_port #(
  parameter int          BSR_LEN = 8,
  parameter logic [31:0] ID_CODE = 32'h1359_A0C3
) (
  input  logic               tck,
  input  logic               trst_n,
  input  logic               tms,
  input  logic               tdi,
  output logic               tdo,
  output logic               tdo_oe,
  input  logic               programmed,
  input  logic [BSR_LEN-1:0] pin_in,
  output logic [BSR_LEN-1:0] pin_out,
  output logic               pin_override
);
  localparam int IRW = 8;
  localparam logic [IRW-1:0] OP_EXT   = 8'h00;
  localparam logic [IRW-1:0] OP_SMP   = 8'h01;
  localparam logic [IRW-1:0] OP_CLAMP = 8'h05;
  localparam logic [IRW-1:0] OP_ID    = 8'h0F;
  localparam logic [IRW-1:0] IR_CAPT  = 8'h01;

  typedef enum logic [3:0] {
    S_EX2DR = 4'h0, S_EX1DR = 4'h1, S_SHDR  = 4'h2, S_PSDR  = 4'h3,
    S_SELIR = 4'h4, S_UPDR  = 4'h5, S_CAPDR = 4'h6, S_SELDR = 4'h7,
    S_EX2IR = 4'h8, S_EX1IR = 4'h9, S_SHIR  = 4'hA, S_PSIR  = 4'hB,
    S_RTI   = 4'hC, S_UPIR  = 4'hD, S_CAPIR = 4'hE, S_TLR   = 4'hF
  } tap_t;

  tap_t st, nx;

  always_comb begin
    case (st)
      S_TLR:   nx = tms ? S_TLR   : S_RTI;
      S_RTI:   nx = tms ? S_SELDR : S_RTI;
      S_SELDR: nx = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nx = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nx = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nx = tms ? S_UPDR  : S_PSDR;
      S_PSDR:  nx = tms ? S_EX2DR : S_PSDR;
      S_EX2DR: nx = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  nx = tms ? S_SELDR : S_RTI;
      S_SELIR: nx = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nx = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nx = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nx = tms ? S_UPIR  : S_PSIR;
      S_PSIR:  nx = tms ? S_EX2IR : S_PSIR;
      S_EX2IR: nx = tms ? S_UPIR  : S_SHIR;
      S_UPIR:  nx = tms ? S_SELDR : S_RTI;
      default: nx = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) st <= S_TLR;
    else         st <= nx;

  logic [IRW-1:0] ir_sh, ir_act;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)            ir_sh <= IR_CAPT;
    else if (st == S_CAPIR) ir_sh <= IR_CAPT;
    else if (st == S_SHIR)  ir_sh <= {tdi, ir_sh[IRW-1:1]};

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)           ir_act <= OP_ID;
    else if (st == S_TLR)  ir_act <= OP_ID;
    else if (st == S_UPIR) ir_act <= ir_sh;

  wire ext_on   = (ir_act == OP_EXT) & programmed;
  wire clamp_on = (ir_act == OP_CLAMP);
  wire use_bsr  = ext_on | (ir_act == OP_SMP);
  wire use_id   = (ir_act == OP_ID);
  wire cap_dr   = (st == S_CAPDR);
  wire sh_dr    = (st == S_SHDR);

  logic               byp;
  logic [31:0]        idr;
  logic [BSR_LEN-1:0] bsr_sh, bsr_upd;

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) begin
      byp    <= 1'b0;
      idr    <= '0;
      bsr_sh <= '0;
    end else begin
      if (cap_dr)     byp <= 1'b0;
      else if (sh_dr) byp <= tdi;
      if (use_id) begin
        if (cap_dr)     idr <= ID_CODE;
        else if (sh_dr) idr <= {tdi, idr[31:1]};
      end
      if (use_bsr) begin
        if (cap_dr)     bsr_sh <= pin_in;
        else if (sh_dr) bsr_sh <= {tdi, bsr_sh[BSR_LEN-1:1]};
      end
    end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)                      bsr_upd <= '0;
    else if (st == S_UPDR && use_bsr) bsr_upd <= bsr_sh;

  logic dr_bit, tdo_q, oe_q;
  assign dr_bit = use_id ? idr[0] : (use_bsr ? bsr_sh[0] : byp);

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= (st == S_SHIR) ? ir_sh[0] : dr_bit;
      oe_q  <= (st == S_SHIR) || (st == S_SHDR);
    end

  assign tdo          = oe_q ? tdo_q : 1'bz;
  assign tdo_oe       = oe_q;
  assign pin_out      = bsr_upd;
  assign pin_override = ext_on | clamp_on;
endmodule

module jtag_tap_port_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic [3:0] st,
  input logic [7:0] ir_act,
  input logic       tdo_oe,
  input logic       programmed,
  input logic       pin_override
);
  localparam logic [3:0] C_TLR = 4'hF, C_UPIR = 4'hD, C_SHIR = 4'hA, C_SHDR = 4'h2;

  a_r1_reset_idcode: assert property (@(posedge tck) disable iff (!trst_n)
    (st == C_TLR) |-> (ir_act == 8'h0F && !tdo_oe));

  a_r2_tms_hold_reset: assert property (@(posedge tck) disable iff (!trst_n)
    (st == C_TLR && tms) |=> (st == C_TLR));

  a_r8_ext_locked: assert property (@(posedge tck) disable iff (!trst_n)
    (!programmed && ir_act == 8'h00) |-> !pin_override);

  a_r9_clamp_drives: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_act == 8'h05) |-> pin_override);

  a_r10_ir_update_only: assert property (@(posedge tck) disable iff (!trst_n)
    (ir_act != $past(ir_act)) |-> (st == C_UPIR || st == C_TLR));

  a_r11_oe_shift_only: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe |-> (st == C_SHIR || st == C_SHDR));
endmodule

bind jtag_tap_port jtag_tap_port_chk chk_i (
  .tck(tck), .trst_n(trst_n), .tms(tms), .st(st), .ir_act(ir_act),
  .tdo_oe(tdo_oe), .programmed(programmed), .pin_override(pin_override)
);

// File: tb/jtag_tap_port_tb.sv
module jtag_tap_port_tb_top;
  localparam int          N  = 8;
  localparam logic [31:0] ID = 32'h1359_A0C3;

  logic tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b1, programmed = 1'b0;
  logic [N-1:0] pin_in = '0;
  wire  [N-1:0] pin_out;
  wire  tdo, tdo_oe, pin_override;

  jtag_tap_port #(.BSR_LEN(N), .ID_CODE(ID)) dut_i (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_oe(tdo_oe),
    .programmed(programmed), .pin_in(pin_in), .pin_out(pin_out), .pin_override(pin_override));

  always #10 tck = ~tck;

  int n_chk = 0, n_bad = 0, cyc = 0;
  logic s_tdo, s_oe;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d);
    @(negedge tck); #2;
    s_tdo = tdo; s_oe = tdo_oe;
    tms = m; tdi = d;
  endtask

  task automatic go_idle();
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
  endtask

  task automatic scan_ir(input logic [7:0] op, output logic [7:0] cap, input bit do_update);
    step(1'b1, 1'b0); step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) begin
      step(i == 7, op[i]);
      cap[i] = s_tdo;
    end
    if (do_update) begin
      step(1'b1, 1'b0); step(1'b0, 1'b0);
    end
  endtask

  task automatic scan_dr(input int len, input logic [31:0] din, output logic [31:0] dout);
    bit oe_ok = 1;
    dout = '0;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    for (int i = 0; i < len; i++) begin
      step(i == len - 1, din[i]);
      dout[i] = s_tdo;
      if (s_oe !== 1'b1) oe_ok = 0;
    end
    step(1'b1, 1'b0);
    chk("R11 oe high during Shift-DR, low in Exit1", {oe_ok, s_oe}, 32'h2);
    step(1'b0, 1'b0);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R1 tdo disabled in reset", {tdo_oe, tdo}, {1'b0, 1'bz});
    chk("R1 no override in reset", pin_override, 0);
    trst_n = 1'b1;
    go_idle();
    chk("R11 tdo off in idle", tdo_oe, 0);
    scan_dr(32, 32'h0, r);
    chk("R4 identification word", r, ID);
  endtask

  task automatic t_ir_capture();
    logic [7:0] c;
    scan_ir(8'hFF, c, 1);
    chk("R3 capture-IR pattern", c, 8'h01);
  endtask

  task automatic t_bypass(input logic [7:0] op, input string req);
    logic [7:0] c; logic [31:0] r;
    scan_ir(op, c, 1);
    scan_dr(8, 32'hB4, r);
    chk(req, r[7:0], 8'h68);
    chk(req, pin_override, 0);
  endtask

  task automatic t_sample();
    logic [7:0] c; logic [31:0] r;
    scan_ir(8'h01, c, 1);
    pin_in = 8'hA5;
    scan_dr(N, 32'h3C, r);
    chk("R6 sample captures pins", r[N-1:0], 8'hA5);
    chk("R6 preload into update stage", pin_out, 8'h3C);
    chk("R6 sample no override", pin_override, 0);
  endtask

  task automatic t_extest_locked();
    logic [7:0] c;
    programmed = 1'b0;
    t_bypass(8'h00, "R8 extest locked acts as bypass");
    scan_ir(8'h00, c, 1);
    chk("R8 locked extest leaves override 0", pin_override, 0);
    chk("R8 update stage unchanged", pin_out, 8'h3C);
  endtask

  task automatic t_extest();
    logic [7:0] c; logic [31:0] r;
    programmed = 1'b1;
    scan_ir(8'h00, c, 1);
    chk("R7 extest override on", pin_override, 1);
    chk("R7 extest drives preload", pin_out, 8'h3C);
    pin_in = 8'h0F;
    scan_dr(N, 32'h5A, r);
    chk("R7 extest captures pins", r[N-1:0], 8'h0F);
    chk("R7 extest new pin value", pin_out, 8'h5A);
  endtask

  task automatic t_ir_hold();
    logic [7:0] c;
    scan_ir(8'hFF, c, 0);
    chk("R10 override held before Update-IR", pin_override, 1);
    step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R10 override dropped after Update-IR", pin_override, 0);
  endtask

  task automatic t_clamp();
    logic [7:0] c; logic [31:0] r;
    scan_ir(8'h05, c, 1);
    chk("R9 clamp override", pin_override, 1);
    scan_dr(8, 32'hB4, r);
    chk("R9 clamp uses bypass", r[7:0], 8'h68);
    chk("R9 clamp holds pins", pin_out, 8'h5A);
  endtask

  task automatic t_tms_reset();
    logic [31:0] r;
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0);
    step(1'b0, 1'b0);
    chk("R2 TLR cleared clamp", pin_override, 0);
    step(1'b0, 1'b0);
    scan_dr(32, 32'h0, r);
    chk("R2 IDCODE after TMS reset", r, ID);
  endtask

  task automatic t_trst();
    logic [7:0] c; logic [31:0] r;
    scan_ir(8'h05, c, 1);
    step(1'b1, 1'b0); step(1'b0, 1'b0); step(1'b0, 1'b0);
    step(1'b0, 1'b1);
    #3 trst_n = 1'b0;
    #1;
    chk("R1 async reset drops override", pin_override, 0);
    chk("R1 async reset disables tdo", tdo_oe, 0);
    #4 trst_n = 1'b1;
    go_idle();
    scan_dr(32, 32'h0, r);
    chk("R1 IDCODE after TRST", r, ID);
  endtask

  initial begin
    #35;
    t_reset();
    t_ir_capture();
    t_bypass(8'hFF, "R5 bypass opcode");
    t_bypass(8'h3C, "R5 unlisted opcode bypass");
    t_sample();
    t_extest_locked();
    t_extest();
    t_ir_hold();
    t_clamp();
    t_tms_reset();
    t_trst();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge tck) begin
    cyc++;
    if (cyc > 20000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual %0d expected <20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule